// File: doc/BRIEF.md
# Dual-Group Parallel Digital I/O Port

This block is a 48-line digital I/O peripheral behind a small 8-bit host bus. It is made of two identical groups, and each group has three 8-bit ports named A, B and C. A host writes a port's data offset to load that port's output latch. The host writes the group's control offset to choose which ports drive their pins and which ports sample them. Port C is split into two nibbles, and each nibble has its own direction. Only plain latched input and output exist. There is no strobed mode and no bidirectional bus mode.

The block decodes a 16-byte window. Each group takes four consecutive offsets: three data bytes followed by one control byte. Group 0 uses offsets 0 to 3 and group 1 uses offsets 4 to 7. Offsets 8 to 15 have nothing behind them.

For each line the block drives three signals:
- a driven value, taken from the output latch;
- an output enable;
- a sampled value, which comes back from the pin.

An external pad model, or a testbench, combines these into the physical pin. A read at a data offset returns a per-bit mix. Bits set as outputs return the latch value and bits set as inputs return the pin value.

Top module: `dual_pio`

## Requirements
- R1: After reset every output enable is 1 and every output latch is 0x00, so all 48 lines drive zero.
- R2: A write to a data offset (group base + 0, 1 or 2 for A, B or C) loads that port's 8-bit latch on the next clock edge. The latch appears on `pin_out` whatever the direction is.
- R3: A control write with bit 7 set makes port A an input when bit 4 is 1 and makes port B an input when bit 1 is 1. A 0 in either bit makes that port an output.
- R4: In the same configuration write, bit 3 = 1 makes port C bits 7:4 inputs and bit 0 = 1 makes port C bits 3:0 inputs. Each nibble is independent of the other.
- R5: A control write with bit 7 clear leaves the directions of that group unchanged.
- R6: A read at a data offset returns, for each bit, the latch bit when that bit is an output and `pin_in` when it is an input.
- R7: A read at a control offset returns 0x80 with the current direction flags at bits 4, 3, 1 and 0. The other bits read 0.
- R8: Group 1 sits at offsets 4 to 7 and drives lines 47:24. Writes to one group never change the other group's latches or directions.
- R9: Offsets 8 to 15 read as 0x00, and writes to them change no latch and no direction.
- R10: A port's latch keeps its contents while the port is an input. When the port turns back into an output it drives that held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 48 | Sampled pin levels, line 8*p+b for port p, bit b |
| pin_out | output | 48 | Output latch values per line |
| pin_oe | output | 48 | Per-line output enable, 1 = drive |

## Verification
The main function is exercised in three ways:
- Random writes over the whole window with random pin levels. This separates the latch path from the pin path, because a readback only matches when each bit takes its source from its own direction.
- Directed configuration words that set only one direction flag at a time. These expose any swapped or shared control bit, including the two Port C nibbles.
- Writes with bit 7 clear, writes to the unused upper half of the window, and direction round trips on a port with a non-zero held latch. These tell "ignored" apart from "cleared" and "retained".

// File: rtl/dual_pio.sv
module dual_pio #(
  parameter int NGRP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NGRP*24-1:0] pin_in,
  output logic [NGRP*24-1:0] pin_out,
  output logic [NGRP*24-1:0] pin_oe
);
  localparam int SLOTS = 4;

  logic [31:0] grp_rd [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_grp
    if (g < NGRP) begin : g_live
      logic [7:0] lat_a, lat_b, lat_c;
      logic       in_a, in_b, in_ch, in_cl;
      logic [23:0] oe, lat, mix;
      wire hit = bus_wr && (bus_addr[3:2] == 2'(g));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lat_a <= '0; lat_b <= '0; lat_c <= '0;
          in_a  <= 1'b0; in_b <= 1'b0; in_ch <= 1'b0; in_cl <= 1'b0;
        end else if (hit) begin
          case (bus_addr[1:0])
            2'd0: lat_a <= bus_wdata;
            2'd1: lat_b <= bus_wdata;
            2'd2: lat_c <= bus_wdata;
            default: if (bus_wdata[7]) begin
              in_a  <= bus_wdata[4];
              in_ch <= bus_wdata[3];
              in_b  <= bus_wdata[1];
              in_cl <= bus_wdata[0];
            end
          endcase
        end
      end

      assign lat = {lat_c, lat_b, lat_a};
      assign oe  = {{4{~in_ch}}, {4{~in_cl}}, {8{~in_b}}, {8{~in_a}}};
      assign mix = (lat & oe) | (pin_in[g*24 +: 24] & ~oe);

      assign pin_out[g*24 +: 24] = lat;
      assign pin_oe[g*24 +: 24]  = oe;
      assign grp_rd[g] = {1'b1, 2'b00, in_a, in_ch, 1'b0, in_b, in_cl, mix};
    end else begin : g_none
      assign grp_rd[g] = '0;
    end
  end

  assign bus_rdata = grp_rd[bus_addr[3:2]][8*bus_addr[1:0] +: 8];
endmodule

// File: rtl/dual_pio_chk.sv
module dual_pio_chk #(
  parameter int NGRP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [3:0]        bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [NGRP*24-1:0] pin_out,
  input logic [NGRP*24-1:0] pin_oe
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '1 && pin_out == '0));

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd0) |=> pin_out[7:0] == $past(bus_wdata));

  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd3 && !bus_wdata[7]) |=> $stable(pin_oe));

  // R8
  group_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd0) |=> $stable(pin_oe[NGRP*24-1:24]) && $stable(pin_out[NGRP*24-1:24]));

  // R9
  unused_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3]) |=> $stable(pin_oe) && $stable(pin_out));
endmodule

bind dual_pio dual_pio_chk #(.NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_dual_pio.sv
`timescale 1ns/1ps
module sim_dual_pio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out, pin_oe;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_lat [6];
  logic [3:0] m_dir [2];

  always #2.5 clk = ~clk;

  dual_pio u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic logic [47:0] exp_oe();
    logic [47:0] r;
    for (int g = 0; g < 2; g++)
      r[g*24 +: 24] = {{4{~m_dir[g][2]}}, {4{~m_dir[g][0]}}, {8{~m_dir[g][1]}}, {8{~m_dir[g][3]}}};
    return r;
  endfunction

  function automatic logic [47:0] exp_out();
    logic [47:0] r;
    for (int p = 0; p < 6; p++) r[p*8 +: 8] = m_lat[p];
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic [47:0] oe;
    int g, p;
    oe = exp_oe();
    if (a[3]) return 8'h00;
    g = int'(a[2]);
    if (a[1:0] == 2'd3)
      return {1'b1, 2'b00, m_dir[g][3], m_dir[g][2], 1'b0, m_dir[g][1], m_dir[g][0]};
    p = g*3 + int'(a[1:0]);
    return (m_lat[p] & oe[p*8 +: 8]) | (pin_in[p*8 +: 8] & ~oe[p*8 +: 8]);
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (!a[3]) begin
      if (a[1:0] != 2'd3) m_lat[int'(a[2])*3 + int'(a[1:0])] = d;
      else if (d[7]) m_dir[int'(a[2])] = {d[4], d[3], d[1], d[0]};
    end
  endtask

  task automatic pins(input string tag);
    chk({tag, " oe"}, pin_oe, exp_oe());
    chk({tag, " out"}, pin_out, exp_out());
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    bus_addr = a;
    #0.5;
    chk(tag, {40'd0, bus_rdata}, {40'd0, exp_rd(a)});
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 6; i++) m_lat[i] = '0;
    m_dir[0] = '0; m_dir[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    pins("R1 reset");
    rd(4'd3, "R1/R7 ctrl0 after reset");

    // R2 latch load and drive
    wr(4'd0, 8'hA5); wr(4'd1, 8'h3C); wr(4'd2, 8'h81);
    pins("R2 latch");
    // R3 port A input only
    pin_in = 48'hF0F0_0F0F_55AA;
    wr(4'd3, 8'h90);
    pins("R3 A in");
    rd(4'd0, "R3/R6 A mix");
    rd(4'd1, "R3/R6 B mix");
    wr(4'd3, 8'h82);
    pins("R3 B in");
    // R4 nibbles
    wr(4'd3, 8'h88);
    pins("R4 C hi in");
    rd(4'd2, "R4/R6 C hi mix");
    wr(4'd3, 8'h81);
    pins("R4 C lo in");
    rd(4'd2, "R4/R6 C lo mix");
    rd(4'd3, "R7 ctrl read");
    // R5 bit7 clear ignored
    wr(4'd3, 8'h1B);
    pins("R5 no config");
    rd(4'd3, "R5 ctrl unchanged");
    // R10 hold while input, then back to output
    wr(4'd3, 8'h9B);
    wr(4'd0, 8'h6E);
    pins("R10 input latch");
    wr(4'd3, 8'h80);
    pins("R10 restore drive");
    // R8 group 1
    wr(4'd7, 8'h92); wr(4'd4, 8'hC3);
    pins("R8 group1");
    rd(4'd4, "R8 g1 A read");
    rd(4'd7, "R8 g1 ctrl");
    rd(4'd3, "R8 g0 ctrl");
    // R9 unused window
    wr(4'd8, 8'hFF); wr(4'd11, 8'h9B); wr(4'd15, 8'h80);
    pins("R9 unused write");
    rd(4'd12, "R9 unused read");

    // random mix: R2 R6 R7 R9
    for (int i = 0; i < 400; i++) begin
      pin_in = {$urandom, $urandom};
      wr(4'($urandom), 8'($urandom));
      pins("R2 rnd");
      rd(4'($urandom), "R6 rnd read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule